// File: doc/BRIEF.md
# Error Bank Register Decoder

This block is the memory-mapped register front end of one bank of hardware error records. A simple request/response bus reaches it with 4-byte and 8-byte reads and writes addressed by byte offset within the bank's address page. The first 64 bytes of the page form a bank header. The header holds an instance identifier, the number of records in the bank, and a summary word. The summary word gathers the valid bit of every record into one bitmap. Software can therefore find the records that hold errors with a single read.

Each record owns a 64-byte slot, and record k begins at byte offset 64 × (k + 1). An access that falls in a record slot goes out on the record-side port as a 32-bit word operation: a read or write strobe for that record, a word index within the slot and the write data. The record's storage and its error-capture logic sit outside this block. An 8-byte access runs as two word operations, low half first and then high half, on consecutive cycles.

Unimplemented offsets read as zero and drop writes. These include the spare header words, every slot beyond the last record and the read-only header fields. Requests with an unsupported size code or a misaligned address also complete with zero data and cause no side effect.

Top module: `ebank_regs`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is 0, `req_ready` is 1, and no record strobe is active while no request is presented.
- R2: An aligned 4-byte request (size code 2, `req_addr[1:0]` = 0) is accepted in the cycle it is presented. It performs one word operation in that cycle, and `rsp_valid` rises one cycle later. Read data is placed in bits 31:0 and bits 63:32 are zero. The response data of any write is zero.
- R3: An aligned 8-byte request (size code 3, `req_addr[2:0]` = 0) performs the low word operation in its accept cycle and the high word operation (offset + 4) in the next cycle. `req_ready` is 0 during that second cycle, and `rsp_valid` rises two cycles after acceptance. For a read, the low word is in bits 31:0 and the high word in bits 63:32.
- R4: Header offset 0x00 reads the instance identifier parameter. Offset 0x04 reads the record count in bits 5:0 and zero above. Writes to either leave them unchanged.
- R5: The summary at header offset 0x08 (64 bits, read as two words at 0x08 and 0x0C) has bit 0 set to 1, which marks the bitmap as meaningful. Bit k+1 equals the current valid input of record k, and it follows that input in the same cycle without a register. All higher bits are zero.
- R6: Offset 64 × (k + 1) + 4 × w, for w from 0 to 15, reaches word w of record k: the read or write strobe of record k only, `rec_word_o` = w, and for writes `rec_wdata_o` carries the data. For an 8-byte write, the low half of `req_wdata` goes to word w and the high half to word w+1.
- R7: Header offsets 0x10 to 0x3F, and offsets at or above 64 × (NUM_REC + 1), read zero, and writes to them drive no record strobe and change no record.
- R8: A request with size code 0 or 1, or a 4-byte request with `req_addr[1:0]` ≠ 0, or an 8-byte request with `req_addr[2:0]` ≠ 0, drives no record strobe. It responds one cycle later with zero data.
- R9: At most one record strobe (read or write, across all records) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 2 = 4 bytes, 3 = 8 bytes, others unsupported |
| req_addr | input | ADDR_W | Byte offset within the bank page |
| req_wdata | input | 64 | Write data (bits 31:0 for 4-byte writes) |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Response read data |
| rec_rd_o | output | NUM_REC | Per-record word read strobe |
| rec_wr_o | output | NUM_REC | Per-record word write strobe |
| rec_word_o | output | 4 | Word index within the record slot |
| rec_wdata_o | output | 32 | Word write data to the records |
| rec_rdata_i | input | 32*NUM_REC | Word read data of each record, for the word at rec_word_o |
| rec_valid_i | input | NUM_REC | Valid bit of each record |

## Verification
The assertions take for granted that `req_valid` is held for one cycle only when `req_ready` is high, and is dropped in the next cycle. They also assume that each record presents the word chosen by `rec_word_o` on `rec_rdata_i` in the same cycle. The stimulus issues one request at a time and waits for its response before it presents the next. Behavioural record memories answer combinationally from the word index, and a separate reference copy of their contents in the bench predicts every read. Record valid inputs change only between requests, so the live summary is checked with a stable bitmap at each read.

// File: rtl/ebank_pkg.sv
// Shared constants and types of the error bank register decoder.
// Assumes byte-offset addressing within one bank page.
package ebank_pkg;
    localparam logic [1:0] SZ_WORD  = 2'd2;   // 4-byte access
    localparam logic [1:0] SZ_DWORD = 2'd3;   // 8-byte access
    localparam int         SLOT_BYTES = 64;   // header and record slot size
    localparam int         SLOT_LSB   = 6;    // log2 of slot size

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIGH = 1'b1
    } seq_state_t;
endpackage

// File: rtl/ebank_route.sv
// Address router: splits a byte offset into slot and word and flags
// whether it hits the header, an implemented record, or nothing.
// Assumes ADDR_W > 6 and NUM_REC between 1 and 63.
module ebank_route #(
    parameter int NUM_REC = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = (NUM_REC > 1) ? $clog2(NUM_REC) : 1,
    localparam int SLOT_W = ADDR_W - ebank_pkg::SLOT_LSB
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              is_hdr_o,
    output logic              is_rec_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [3:0]        word_o
);
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] slot_m1;

    // Slot decode of the current access address.
    always_comb begin
        slot     = addr_i[ADDR_W-1:ebank_pkg::SLOT_LSB];
        slot_m1  = slot - SLOT_W'(1);
        is_hdr_o = (slot == '0);
        is_rec_o = (slot != '0) && (slot <= SLOT_W'(NUM_REC));
        idx_o    = slot_m1[IDX_W-1:0];
        word_o   = addr_i[5:2];
    end
endmodule

// File: rtl/ebank_hdr.sv
// Bank header read mux: identifier, record count and the live summary
// of record valid bits. Header is read-only; spare words read zero.
module ebank_hdr #(
    parameter int          NUM_REC = 4,
    parameter logic [31:0] INST_ID = 32'h1A2B_0001
) (
    input  logic [3:0]         word_i,
    input  logic [NUM_REC-1:0] rec_valid_i,
    output logic [31:0]        rdata_o
);
    logic [63:0] summary;

    // Build the summary: bit 0 flags a meaningful bitmap, record k at bit k+1.
    always_comb begin
        summary              = '0;
        summary[0]           = 1'b1;
        summary[NUM_REC:1]   = rec_valid_i;
    end

    // Select the addressed header word.
    always_comb begin
        case (word_i)
            4'd0:    rdata_o = INST_ID;
            4'd1:    rdata_o = {26'd0, 6'(NUM_REC)};
            4'd2:    rdata_o = summary[31:0];
            4'd3:    rdata_o = summary[63:32];
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ebank_seq.sv
// Access sequencer: checks size and alignment, runs an 8-byte access as
// a low then a high word operation, and forms the response.
// Assumes word read data is valid in the cycle of each word operation.
module ebank_seq #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata_hi,
    input  logic [31:0]       word_rdata,
    output logic              req_ready,
    output logic              legal_o,
    output logic              in_high_o,
    output logic              lat_wr_o,
    output logic [31:0]       lat_wdata_o,
    output logic [ADDR_W-1:0] hi_addr_o,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata
);
    import ebank_pkg::*;

    seq_state_t  state;
    logic [31:0] lo_q;

    // Size and alignment check of the presented request.
    always_comb begin
        legal_o = ((req_size == SZ_WORD)  && (req_addr[1:0] == 2'b00)) ||
                  ((req_size == SZ_DWORD) && (req_addr[2:0] == 3'b000));
    end

    assign req_ready = (state == ST_IDLE);
    assign in_high_o = (state == ST_HIGH);

    // Sequencer state, latched high-half context and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            lo_q        <= '0;
            lat_wr_o    <= 1'b0;
            lat_wdata_o <= '0;
            hi_addr_o   <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (state == ST_HIGH) begin
                state     <= ST_IDLE;
                rsp_valid <= 1'b1;
                rsp_rdata <= lat_wr_o ? 64'd0 : {word_rdata, lo_q};
            end else if (req_valid) begin
                if (legal_o && req_size == SZ_DWORD) begin
                    state       <= ST_HIGH;
                    lo_q        <= word_rdata;
                    lat_wr_o    <= req_write;
                    lat_wdata_o <= req_wdata_hi;
                    hi_addr_o   <= {req_addr[ADDR_W-1:3], 3'b100};
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= (legal_o && !req_write) ? {32'd0, word_rdata} : 64'd0;
                end
            end
        end
    end
endmodule

// File: rtl/ebank_regs.sv
// Error bank register decoder top: routes header and record accesses,
// drives one-hot record word strobes and returns responses.
// Assumes requests are held for one cycle while req_ready is high.
module ebank_regs #(
    parameter int          NUM_REC = 4,
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] INST_ID = 32'h1A2B_0001,
    localparam int         IDX_W   = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [63:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [63:0]           rsp_rdata,
    output logic [NUM_REC-1:0]    rec_rd_o,
    output logic [NUM_REC-1:0]    rec_wr_o,
    output logic [3:0]            rec_word_o,
    output logic [31:0]           rec_wdata_o,
    input  logic [32*NUM_REC-1:0] rec_rdata_i,
    input  logic [NUM_REC-1:0]    rec_valid_i
);
    logic              legal, in_high, lat_wr, op_act, cur_wr;
    logic [31:0]       lat_wdata, hdr_rdata, word_rdata;
    logic [ADDR_W-1:0] hi_addr, cur_addr;
    logic              is_hdr, is_rec;
    logic [IDX_W-1:0]  idx;
    logic [3:0]        word;
    logic [31:0]       rec_word_sel [NUM_REC];

    ebank_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata_hi(req_wdata[63:32]),
        .word_rdata(word_rdata), .req_ready(req_ready), .legal_o(legal),
        .in_high_o(in_high), .lat_wr_o(lat_wr), .lat_wdata_o(lat_wdata),
        .hi_addr_o(hi_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Current word operation: the presented request or the latched high half.
    always_comb begin
        cur_addr    = in_high ? hi_addr : req_addr;
        cur_wr      = in_high ? lat_wr : req_write;
        rec_wdata_o = in_high ? lat_wdata : req_wdata[31:0];
        op_act      = in_high || (req_ready && req_valid && legal);
    end

    ebank_route #(.NUM_REC(NUM_REC), .ADDR_W(ADDR_W)) u_route (
        .addr_i(cur_addr), .is_hdr_o(is_hdr), .is_rec_o(is_rec),
        .idx_o(idx), .word_o(word)
    );

    ebank_hdr #(.NUM_REC(NUM_REC), .INST_ID(INST_ID)) u_hdr (
        .word_i(word), .rec_valid_i(rec_valid_i), .rdata_o(hdr_rdata)
    );

    assign rec_word_o = word;

    // Per-record strobes and read data slices.
    for (genvar k = 0; k < NUM_REC; k++) begin : g_rec
        assign rec_rd_o[k]     = op_act && is_rec && !cur_wr && (idx == IDX_W'(k));
        assign rec_wr_o[k]     = op_act && is_rec &&  cur_wr && (idx == IDX_W'(k));
        assign rec_word_sel[k] = rec_rdata_i[32*k +: 32];
    end

    // Word read data of the current operation; unimplemented reads zero.
    always_comb begin
        if (is_hdr)      word_rdata = hdr_rdata;
        else if (is_rec) word_rdata = rec_word_sel[idx];
        else             word_rdata = '0;
    end
endmodule

// File: rtl/ebank_regs_chk.sv
// Property checker for the error bank register decoder, bound to the top.
module ebank_regs_chk #(
    parameter int NUM_REC = 4,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [1:0]         req_size,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic [63:0]        rsp_rdata,
    input logic [NUM_REC-1:0] rec_rd_o,
    input logic [NUM_REC-1:0] rec_wr_o
);
    logic accept, ok_w, ok_d;
    assign accept = req_valid && req_ready;
    assign ok_w   = (req_size == 2'd2) && (req_addr[1:0] == 2'b00);
    assign ok_d   = (req_size == 2'd3) && (req_addr[2:0] == 3'b000);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |-> ((rec_rd_o | rec_wr_o) == '0));
    // R2
    narrow_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ok_w) |=> rsp_valid);
    // R3
    wide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ok_d) |=> (!req_ready && !rsp_valid));
    // R3
    wide_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (rsp_valid && req_ready));
    // R7
    hdr_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_addr < ADDR_W'(64)) |-> ((rec_rd_o | rec_wr_o) == '0));
    // R8
    bad_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ok_w && !ok_d) |-> ((rec_rd_o | rec_wr_o) == '0));
    // R8
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ok_w && !ok_d) |=> (rsp_valid && rsp_rdata == 64'd0));
    // R9
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rec_rd_o | rec_wr_o));
endmodule

bind ebank_regs ebank_regs_chk #(.NUM_REC(NUM_REC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rec_rd_o(rec_rd_o), .rec_wr_o(rec_wr_o)
);

// File: tb/ebank_regs_tb.sv
module ebank_regs_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          NREC = 4;
    localparam int          AW   = 12;
    localparam logic [31:0] IID  = 32'h1A2B_0001;

    logic            clk = 0, rst_n = 0;
    logic            req_valid = 0, req_write = 0;
    logic [1:0]      req_size = 0;
    logic [AW-1:0]   req_addr = 0;
    logic [63:0]     req_wdata = 0;
    logic            req_ready, rsp_valid;
    logic [63:0]     rsp_rdata;
    logic [NREC-1:0] rec_rd_o, rec_wr_o, rec_valid_i = 0;
    logic [3:0]      rec_word_o;
    logic [31:0]     rec_wdata_o;
    logic [32*NREC-1:0] rec_rdata_i;

    logic [31:0] slice_mem [NREC][16];
    logic [31:0] ref_mem   [NREC][16];

    int    checks = 0, errors = 0, cycles = 0;
    bit    done = 0;
    bit    exp_v = 0, exp_rdy = 1;
    logic [63:0] exp_d = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    ebank_regs #(.NUM_REC(NREC), .ADDR_W(AW), .INST_ID(IID)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rec_rd_o(rec_rd_o), .rec_wr_o(rec_wr_o), .rec_word_o(rec_word_o),
        .rec_wdata_o(rec_wdata_o), .rec_rdata_i(rec_rdata_i),
        .rec_valid_i(rec_valid_i)
    );

    // Behavioural record slices answering the selected word.
    always_comb
        for (int k = 0; k < NREC; k++) rec_rdata_i[32*k +: 32] = slice_mem[k][rec_word_o];
    always @(posedge clk)
        for (int k = 0; k < NREC; k++) if (rec_wr_o[k]) slice_mem[k][rec_word_o] <= rec_wdata_o;

    task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Reference word of the bank at a byte offset.
    function automatic logic [31:0] model_word(int a);
        int slot = a / 64, w = (a % 64) / 4;
        if (slot == 0) begin
            case (w)
                0: return IID;
                1: return 32'(NREC);
                2: return {27'd0, rec_valid_i, 1'b1};
                default: return 32'd0;
            endcase
        end
        if (slot <= NREC) return ref_mem[slot-1][w];
        return 32'd0;
    endfunction

    task automatic model_write(int a, logic [31:0] d);
        int slot = a / 64;
        if (slot >= 1 && slot <= NREC) ref_mem[slot-1][(a % 64) / 4] = d;
    endtask

    // Per-clock comparison against the reference.
    initial forever begin
        @(negedge clk);
        cycles++;
        if (rst_n) begin
            chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'(exp_v));
            if (exp_v) chk({tag, " rsp_rdata"}, rsp_rdata, exp_d);
            chk("R3 req_ready", 64'(req_ready), 64'(exp_rdy));
            chk("R9 one strobe", 64'($countones(rec_rd_o | rec_wr_o) <= 1), 64'd1);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic xfer(string t, bit wr, logic [1:0] sz, int a, logic [63:0] wd);
        bit legal = (sz == 2 && a % 4 == 0) || (sz == 3 && a % 8 == 0);
        logic [63:0] ed = 0;
        if (legal && !wr) ed = (sz == 3) ? {model_word(a + 4), model_word(a)}
                                         : {32'd0, model_word(a)};
        @(posedge clk); #1;
        tag = t;
        req_valid = 1; req_write = wr; req_size = sz;
        req_addr = AW'(a); req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 0;
        if (legal && sz == 3) begin
            exp_rdy = 0;
            @(posedge clk); #1;
            exp_rdy = 1;
        end
        exp_v = 1; exp_d = ed;
        @(posedge clk); #1;
        exp_v = 0;
        if (legal && wr) begin
            model_write(a, wd[31:0]);
            if (sz == 3) model_write(a + 4, wd[63:32]);
        end
    endtask

    initial begin
        for (int k = 0; k < NREC; k++)
            for (int w = 0; w < 16; w++) begin
                slice_mem[k][w] = 32'h5000_0000 + 32'(k * 16 + w);
                ref_mem[k][w]   = 32'h5000_0000 + 32'(k * 16 + w);
            end
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", 64'(rsp_valid), 0);
        chk("R1 reset req_ready", 64'(req_ready), 1);
        chk("R1 reset strobes", 64'(rec_rd_o | rec_wr_o), 0);
        @(posedge clk); #1; rst_n = 1;

        xfer("R4 inst id", 0, 2, 0, 0);
        xfer("R4 count", 0, 2, 4, 0);
        xfer("R3 header dword", 0, 3, 0, 0);
        xfer("R4 header write ignored", 1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        xfer("R4 header after write", 0, 3, 0, 0);
        rec_valid_i = 4'b1010;
        xfer("R5 summary low", 0, 2, 8, 0);
        rec_valid_i = 4'b0001;
        xfer("R5 summary live", 0, 3, 8, 0);
        rec_valid_i = 4'b1111;
        xfer("R5 summary all", 0, 2, 8, 0);
        xfer("R6 rec0 word0 read", 0, 2, 64, 0);
        xfer("R2 rec0 word0 write", 1, 2, 64, 64'hDEAD_0000_AAAA_0001);
        xfer("R2 rec0 word0 readback", 0, 2, 64, 0);
        xfer("R6 rec3 word15 write", 1, 2, 316, 64'h0000_0000_3333_000F);
        xfer("R6 rec3 word15 readback", 0, 2, 316, 0);
        xfer("R6 rec2 word5 read", 0, 2, 212, 0);
        xfer("R3 rec1 dword write", 1, 3, 136, 64'h1111_2222_3333_4444);
        xfer("R3 rec1 low half", 0, 2, 136, 0);
        xfer("R3 rec1 high half", 0, 2, 140, 0);
        xfer("R3 rec1 dword read", 0, 3, 136, 0);
        xfer("R7 spare header", 0, 2, 16, 0);
        xfer("R7 spare header top", 0, 3, 56, 0);
        xfer("R7 beyond last write", 1, 2, 320, 64'h0000_0000_BAD0_BAD0);
        xfer("R7 beyond last read", 0, 2, 320, 0);
        xfer("R7 rec0 not aliased", 0, 2, 64, 0);
        xfer("R7 far offset", 0, 3, 4088, 0);
        xfer("R8 misaligned write", 1, 2, 66, 64'h0000_0000_BAD1_BAD1);
        xfer("R8 odd size write", 1, 2'd1, 64, 64'h0000_0000_BAD2_BAD2);
        xfer("R8 size0 read", 0, 2'd0, 64, 0);
        xfer("R8 dword misaligned read", 0, 3, 68, 0);
        xfer("R8 dword misaligned write", 1, 3, 132, 64'hBAD3_BAD3_BAD3_BAD3);
        xfer("R8 rec0 unchanged", 0, 2, 64, 0);
        xfer("R8 rec1 unchanged", 0, 3, 128, 0);
        xfer("R9 rec2 dword read", 0, 3, 192, 0);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule